// File: doc/BRIEF.md
# Indirect Register Access Engine

This block lets a processor reach internal storage that has no place in its own address map, such as long cell buffers, along with a bank of wide event counters that keep running. The processor loads an address window and, for a write, a data window, then writes a transfer command. The engine hands one request to the storage side, waits however long the storage needs, and raises a ready bit once the move is complete. On a read, the data window then holds the fetched word.

For counters, the processor writes a counter index to a separate command register. One cycle later, all bits of that counter are copied into a snapshot register in a single cycle. The snapshot stays put while the live counter keeps counting. Completion of either kind of move, and a set of external event lines, set sticky status bits. Software clears a status bit by writing a zero to it. A matching enable register gates the status bits onto one level-sensitive interrupt line.

Top module: `iax_engine`

## Requirements
- R1: After reset, the transfer command register reads 1 (bit 0 ready = 1, bit 1 busy = 0). The counter command register reads 1 (ready). Status, enable, both windows and the snapshot read 0, and `irq` is 0.
- R2: Writing register address 2 with bit 0 = 1 and bit 1 = 1 while idle issues exactly one single-cycle `st_req` with `st_we` = 1. It carries the address window (register 0) and the data window (register 1), so the storage at that address receives the data.
- R3: A transfer started with bit 0 = 1 and bit 1 = 0 loads the storage word returned with `st_done` into the data window, which is read back at register address 1.
- R4: An accepted start clears the ready bit (register 2 bit 0) and sets busy (bit 1) on the next cycle. Ready returns to 1 only once the storage signals `st_done`, for any storage latency, including about 200 cycles.
- R5: While a transfer is busy, further start commands and writes to the address or data window have no effect. No extra request is issued, and the windows keep their values.
- R6: Writing a counter index (bits 1:0) to register address 3 clears the counter ready bit (register 3 bit 0). On the following cycle, the full 24-bit value of that counter is copied in one cycle into the snapshot (register address 4) and ready is set. The snapshot then holds its value while the live counter advances.
- R7: Status register (address 5) bits are sticky. Bit 0 is set by transfer completion, bit 1 by snapshot completion, and bit 2+k by a high level on `ev_in[k]`. A bit stays set until software clears it.
- R8: A write to the status register clears exactly the bits written as 0 and leaves the bits written as 1 unchanged. A set arriving in the same cycle as a clearing write wins.
- R9: The enable register (address 6) reads back what was written. `irq` is high exactly when some status bit and its enable bit are both 1, as a level.
- R10: Register address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Processor register address |
| reg_we | input | 1 | Processor write strobe |
| reg_wdata | input | 32 | Processor write data |
| reg_rdata | output | 32 | Processor read data for `reg_addr` |
| ev_in | input | 4 | Event lines that set status bits 2 to 5 |
| cnt_live | input | 96 | Four live 24-bit counters, counter 0 in the low bits |
| st_req | output | 1 | Single-cycle storage request |
| st_we | output | 1 | Request direction, 1 = write storage |
| st_addr | output | 12 | Storage address of the request |
| st_wdata | output | 32 | Storage write data |
| st_rdata | input | 32 | Storage read data, valid with `st_done` |
| st_done | input | 1 | Storage completion pulse |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the storage side answers each request with exactly one `st_done` pulse. That pulse comes no earlier than the cycle after the request and never without one outstanding. The assertions also assume that the processor writes one register per cycle. The bench storage model only counts down a latency that starts after it sees `st_req`, so it never raises `st_done` unprompted. The bench drives register writes through a task that holds `reg_we` for exactly one cycle. Random latencies run from 1 to 40 cycles, and a directed case uses 200.

// File: rtl/iax_pkg.sv
`timescale 1ns/1ps
package iax_pkg;
  localparam int unsigned RA_W = 3;
  localparam logic [RA_W-1:0] RA_WADDR = 3'd0;
  localparam logic [RA_W-1:0] RA_WDATA = 3'd1;
  localparam logic [RA_W-1:0] RA_XCMD  = 3'd2;
  localparam logic [RA_W-1:0] RA_CCMD  = 3'd3;
  localparam logic [RA_W-1:0] RA_CSNAP = 3'd4;
  localparam logic [RA_W-1:0] RA_STAT  = 3'd5;
  localparam logic [RA_W-1:0] RA_IEN   = 3'd6;

  localparam int unsigned SB_XFER = 0;
  localparam int unsigned SB_SNAP = 1;
  localparam int unsigned SB_EV0  = 2;

  typedef enum logic [1:0] {XS_IDLE, XS_ISSUE, XS_WAIT} xfer_st_e;
endpackage

// File: rtl/iax_xfer.sv
`timescale 1ns/1ps
module iax_xfer import iax_pkg::*; #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          waddr_we,
  input  logic          wdata_we,
  input  logic          cmd_we,
  input  logic [DW-1:0] wdat,
  input  logic          st_done,
  input  logic [DW-1:0] st_rdata,
  output logic [AW-1:0] win_addr,
  output logic [DW-1:0] win_data,
  output logic          ready,
  output logic          busy,
  output logic          done,
  output logic          st_req,
  output logic          st_we,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_wdata
);
  xfer_st_e      st_q, st_d;
  logic          ready_q, ready_d;
  logic          dir_q, dir_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          start;

  assign start = cmd_we && wdat[0];

  always_comb begin
    st_d    = st_q;
    ready_d = ready_q;
    dir_d   = dir_q;
    addr_d  = addr_q;
    data_d  = data_q;
    done    = 1'b0;
    case (st_q)
      XS_IDLE: begin
        if (waddr_we) addr_d = wdat[AW-1:0];
        if (wdata_we) data_d = wdat;
        if (start) begin
          st_d    = XS_ISSUE;
          ready_d = 1'b0;
          dir_d   = wdat[1];
        end
      end
      XS_ISSUE: st_d = XS_WAIT;
      XS_WAIT: begin
        if (st_done) begin
          st_d    = XS_IDLE;
          ready_d = 1'b1;
          done    = 1'b1;
          if (!dir_q) data_d = st_rdata;
        end
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      ready_q <= 1'b1;
      dir_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      ready_q <= ready_d;
      dir_q   <= dir_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign win_addr = addr_q;
  assign win_data = data_q;
  assign ready    = ready_q;
  assign busy     = (st_q != XS_IDLE);
  assign st_req   = (st_q == XS_ISSUE);
  assign st_we    = dir_q;
  assign st_addr  = addr_q;
  assign st_wdata = data_q;

  assert_start_clears_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (!ready && st_req));
  assert_ready_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XS_WAIT && st_done) |=> (ready && !busy));
  assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);
  assert_single_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |=> !st_req);
  assert_window_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(win_addr));
endmodule

// File: rtl/iax_snap.sv
`timescale 1ns/1ps
module iax_snap #(
  parameter int unsigned CW   = 24,
  parameter int unsigned NCNT = 4,
  localparam int unsigned IW  = (NCNT > 1) ? $clog2(NCNT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic [IW-1:0]      idx,
  input  logic [NCNT*CW-1:0] cnt_live,
  output logic [CW-1:0]      snap,
  output logic               ready,
  output logic               done
);
  logic [CW-1:0] cnt_a [NCNT];
  logic          pend_q, pend_d;
  logic          ready_q, ready_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] snap_q, snap_d;
  logic [CW-1:0] sel;

  for (genvar k = 0; k < NCNT; k++) begin : g_unpack
    assign cnt_a[k] = cnt_live[k*CW +: CW];
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < NCNT; k++) begin
      if (idx_q == IW'(k)) sel = cnt_a[k];
    end
  end

  always_comb begin
    pend_d  = pend_q;
    ready_d = ready_q;
    idx_d   = idx_q;
    snap_d  = snap_q;
    done    = 1'b0;
    if (pend_q) begin
      snap_d  = sel;
      pend_d  = 1'b0;
      ready_d = 1'b1;
      done    = 1'b1;
    end else if (cmd_we) begin
      idx_d   = idx;
      pend_d  = 1'b1;
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      ready_q <= 1'b1;
      idx_q   <= '0;
      snap_q  <= '0;
    end else begin
      pend_q  <= pend_d;
      ready_q <= ready_d;
      idx_q   <= idx_d;
      snap_q  <= snap_d;
    end
  end

  assign snap  = snap_q;
  assign ready = ready_q;

  assert_cmd_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && cmd_we) |=> !ready);
  assert_ready_after_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> ready);
  assert_snap_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(snap));
endmodule

// File: rtl/iax_stat.sv
`timescale 1ns/1ps
module iax_stat #(
  parameter int unsigned NS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set,
  input  logic          stat_we,
  input  logic          ien_we,
  input  logic [NS-1:0] wdat,
  output logic [NS-1:0] stat,
  output logic [NS-1:0] ien,
  output logic          irq
);
  logic [NS-1:0] stat_q, stat_d;
  logic [NS-1:0] ien_q, ien_d;

  always_comb begin
    stat_d = stat_q;
    if (stat_we) stat_d = stat_q & wdat;
    stat_d = stat_d | set;
    ien_d  = ien_we ? wdat : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= stat_d;
      ien_q  <= ien_d;
    end
  end

  assign stat = stat_q;
  assign ien  = ien_q;
  assign irq  = |(stat_q & ien_q);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((stat & $past(stat)) == $past(stat)));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((stat & $past(set)) == $past(set)));
  assert_zero_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && set == '0) |=> ((stat & ~$past(wdat)) == '0));
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: rtl/iax_engine.sv
`timescale 1ns/1ps
module iax_engine import iax_pkg::*; #(
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 24,
  parameter int unsigned NCNT = 4,
  parameter int unsigned NEV  = 4,
  localparam int unsigned NS  = SB_EV0 + NEV,
  localparam int unsigned IW  = (NCNT > 1) ? $clog2(NCNT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic               reg_we,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic [NEV-1:0]     ev_in,
  input  logic [NCNT*CW-1:0] cnt_live,
  output logic               st_req,
  output logic               st_we,
  output logic [AW-1:0]      st_addr,
  output logic [DW-1:0]      st_wdata,
  input  logic [DW-1:0]      st_rdata,
  input  logic               st_done,
  output logic               irq
);
  logic [1:0]    rs_q;
  logic          rst_i_n;
  logic          we_waddr, we_wdata, we_xcmd, we_ccmd, we_stat, we_ien;
  logic [AW-1:0] win_addr;
  logic [DW-1:0] win_data;
  logic          x_ready, x_busy, x_done;
  logic [CW-1:0] snap;
  logic          c_ready, c_done;
  logic [NS-1:0] stat, ien, set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign we_waddr = reg_we && (reg_addr == RA_WADDR);
  assign we_wdata = reg_we && (reg_addr == RA_WDATA);
  assign we_xcmd  = reg_we && (reg_addr == RA_XCMD);
  assign we_ccmd  = reg_we && (reg_addr == RA_CCMD);
  assign we_stat  = reg_we && (reg_addr == RA_STAT);
  assign we_ien   = reg_we && (reg_addr == RA_IEN);

  iax_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_i_n),
    .waddr_we(we_waddr), .wdata_we(we_wdata), .cmd_we(we_xcmd), .wdat(reg_wdata),
    .st_done(st_done), .st_rdata(st_rdata),
    .win_addr(win_addr), .win_data(win_data),
    .ready(x_ready), .busy(x_busy), .done(x_done),
    .st_req(st_req), .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata)
  );

  iax_snap #(.CW(CW), .NCNT(NCNT)) u_snap (
    .clk(clk), .rst_n(rst_i_n),
    .cmd_we(we_ccmd), .idx(reg_wdata[IW-1:0]), .cnt_live(cnt_live),
    .snap(snap), .ready(c_ready), .done(c_done)
  );

  always_comb begin
    set_v          = '0;
    set_v[SB_XFER] = x_done;
    set_v[SB_SNAP] = c_done;
    set_v[NS-1:SB_EV0] = ev_in;
  end

  iax_stat #(.NS(NS)) u_stat (
    .clk(clk), .rst_n(rst_i_n),
    .set(set_v), .stat_we(we_stat), .ien_we(we_ien), .wdat(reg_wdata[NS-1:0]),
    .stat(stat), .ien(ien), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_WADDR: reg_rdata[AW-1:0] = win_addr;
      RA_WDATA: reg_rdata         = win_data;
      RA_XCMD:  reg_rdata[1:0]    = {x_busy, x_ready};
      RA_CCMD:  reg_rdata[0]      = c_ready;
      RA_CSNAP: reg_rdata[CW-1:0] = snap;
      RA_STAT:  reg_rdata[NS-1:0] = stat;
      RA_IEN:   reg_rdata[NS-1:0] = ien;
      default:  reg_rdata         = '0;
    endcase
  end

  assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> (stat != '0));
  assert_done_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    x_done |=> stat[SB_XFER]);
endmodule

// File: tb/test_iax_engine.sv
`timescale 1ns/1ps
module test_iax_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic [3:0]  ev_in;
  logic [95:0] cnt_live;
  logic        st_req, st_we, st_done;
  logic [11:0] st_addr;
  logic [31:0] st_wdata, st_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  iax_engine i_iax_engine (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in), .cnt_live(cnt_live),
    .st_req(st_req), .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata),
    .st_rdata(st_rdata), .st_done(st_done), .irq(irq)
  );

  // storage model and independent expected contents
  logic [31:0] mem     [4096];
  logic [31:0] exp_mem [4096];
  logic [31:0] rdq;
  int lat_cfg = 1, left = 0, req_cnt = 0;
  logic pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; st_done <= 1'b0; st_rdata <= '0;
    end else begin
      st_done <= 1'b0;
      if (st_req) begin
        req_cnt++;
        if (st_we) mem[st_addr] <= st_wdata;
        rdq <= mem[st_addr]; pend <= 1'b1; left <= lat_cfg;
      end else if (pend) begin
        if (left <= 1) begin st_done <= 1'b1; st_rdata <= rdq; pend <= 1'b0; end
        else left <= left - 1;
      end
    end
  end

  // live counters
  logic [23:0] cnt [4];
  bit cnt_run = 0;
  always @(posedge clk)
    if (cnt_run) for (int k = 0; k < 4; k++) cnt[k] <= cnt[k] + 24'(k + 1);
  assign cnt_live = {cnt[3], cnt[2], cnt[1], cnt[0]};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_ready(output int cycles);
    logic [31:0] v;
    cycles = 0;
    for (int i = 0; i < 600; i++) begin
      rd(3'd2, v);
      if (v[0]) break;
      @(negedge clk); cycles++;
    end
  endtask

  function automatic logic [31:0] xcmd_word(bit wr_dir);
    return {30'd0, wr_dir, 1'b1};
  endfunction

  task automatic do_write(logic [11:0] a, logic [31:0] d, int lat);
    int c;
    lat_cfg = lat;
    wr(3'd0, {20'd0, a}); wr(3'd1, d); wr(3'd2, xcmd_word(1));
    exp_mem[a] = d;
    wait_ready(c);
  endtask

  task automatic do_read(logic [11:0] a, int lat, output logic [31:0] d);
    int c;
    lat_cfg = lat;
    wr(3'd0, {20'd0, a}); wr(3'd2, xcmd_word(0));
    wait_ready(c);
    rd(3'd1, d);
  endtask

  task automatic do_snap(int idx, string tag);
    logic [31:0] v; logic [23:0] e;
    wr(3'd3, 32'(idx));
    e = cnt[idx];
    rd(3'd3, v); chk({tag, " counter ready cleared"}, v, 32'd0);
    @(negedge clk);
    rd(3'd3, v); chk({tag, " counter ready set"}, v, 32'd1);
    rd(3'd4, v); chk({tag, " snapshot value"}, v, {8'd0, e});
    repeat (5) @(negedge clk);
    rd(3'd4, v); chk({tag, " snapshot held"}, v, {8'd0, e});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, d;
    int c, r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    for (int k = 0; k < 4; k++) cnt[k] = 24'hFFFFF0 + 24'(k);
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; ev_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R10 unused address
    rd(3'd2, v); chk("R1 transfer cmd", v, 32'd1);
    rd(3'd3, v); chk("R1 counter cmd", v, 32'd1);
    rd(3'd5, v); chk("R1 status", v, 32'd0);
    rd(3'd6, v); chk("R1 enable", v, 32'd0);
    rd(3'd0, v); chk("R1 addr window", v, 32'd0);
    rd(3'd1, v); chk("R1 data window", v, 32'd0);
    rd(3'd4, v); chk("R1 snapshot", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd7, v); chk("R10 unused address", v, 32'd0);

    // R2 R4 R5 long write transfer with commands while busy
    lat_cfg = 200; r0 = req_cnt;
    wr(3'd0, 32'h123); wr(3'd1, 32'hA5A5_3C3C); wr(3'd2, xcmd_word(1));
    exp_mem[12'h123] = 32'hA5A5_3C3C;
    rd(3'd2, v); chk("R4 ready cleared busy set", v, 32'd2);
    wr(3'd0, 32'h456); wr(3'd1, 32'h0BAD_F00D); wr(3'd2, xcmd_word(0));
    repeat (100) @(negedge clk);
    rd(3'd2, v); chk("R4 still busy mid transfer", v, 32'd2);
    wait_ready(c);
    rd(3'd2, v); chk("R4 ready after done", v, 32'd1);
    chk("R5 one request only", 32'(req_cnt - r0), 32'd1);
    chk("R2 storage written", mem[12'h123], 32'hA5A5_3C3C);
    rd(3'd0, v); chk("R5 addr window kept", v, 32'h123);
    rd(3'd1, v); chk("R5 data window kept", v, 32'hA5A5_3C3C);

    // R3 read back with short latency
    do_read(12'h123, 1, d); chk("R3 read data window", d, 32'hA5A5_3C3C);

    // R7 R8 status clear by zero
    rd(3'd5, v); chk("R7 transfer status set", v & 32'h1, 32'h1);
    wr(3'd5, 32'hFFFF_FFFE);
    rd(3'd5, v); chk("R8 zero clears bit0", v, 32'd0);
    @(negedge clk); ev_in = 4'b0100; @(negedge clk); ev_in = '0;
    repeat (3) @(negedge clk);
    rd(3'd5, v); chk("R7 event bit sticky", v, 32'h10);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R8 ones keep bits", v, 32'h10);
    @(negedge clk);
    reg_addr = 3'd5; reg_wdata = 32'd0; reg_we = 1'b1; ev_in = 4'b0001;
    @(negedge clk); reg_we = 1'b0; ev_in = '0;
    rd(3'd5, v); chk("R8 set wins over clear", v, 32'h04);

    // R9 interrupt
    chk("R9 irq off when disabled", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h04);
    rd(3'd6, v); chk("R9 enable readback", v, 32'h04);
    #1; chk("R9 irq on", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h08); #1;
    chk("R9 irq other bit masked", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h04); wr(3'd5, 32'd0); #1;
    chk("R9 irq off after clear", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'd0);

    // R6 counter snapshot, frozen then running across wrap
    do_snap(2, "R6 frozen");
    rd(3'd5, v); chk("R7 snapshot status", v & 32'h2, 32'h2);
    cnt_run = 1;
    do_snap(1, "R6 running");
    do_snap(3, "R6 running wrap");
    wr(3'd5, 32'd0);

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [11:0] a; logic [31:0] dd;
      a = 12'($urandom % 4096);
      case ($urandom % 3)
        0: do_write(a, $urandom, 1 + int'($urandom % 40));
        1: begin
             do_read(a, 1 + int'($urandom % 40), dd);
             chk("R3 random read", dd, exp_mem[a]);
           end
        default: do_snap(int'($urandom % 4), "R6 random");
      endcase
    end
    rd(3'd5, v); chk("R7 random completions sticky", v & 32'h3, 32'h3);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule